// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause 22 MDIO management master that a processor drives through two 32-bit registers on a simple write/read port. A control register enables the controller, sets the MDC divider, and reports idle and fault status. A command register packs one PHY access into a single word. Writing that word with its start bit set sends one management frame. The start bit then reads as 1 until the frame has ended and clears by itself.

The block divides the functional clock to make MDC. It shifts each frame out on a three-wire MDIO pad interface: output, output enable and input. The frame starts with a run of preamble ones. The header follows, then either write data driven by the master or read data returned by the PHY. During a read the master lets go of the line at turnaround. It then samples the PHY's acknowledge and sixteen data bits on rising MDC edges, and it changes its own output only while MDC is low. The register port has no handshake: a write takes effect in the cycle `reg_we` is high, and `reg_rdata` shows the register selected by `reg_addr` in the same cycle.

Top module: `mdio_mgmt_master`

## Requirements
- R1: Out of reset, the control register (address 0) reads 0x800000FF: busy-free flag at bit 31 set, enable at bit 30 clear, divider at bits 15:0 equal to 255. The command register (address 1) reads 0, MDC is low and MDIO is not driven.
- R2: While enabled, one MDC period lasts divider+1 functional clocks, with MDC high for floor((divider+1)/2) of them. A divider of 0 acts as 1. While disabled, MDC stays low.
- R3: Each frame is sent MSB first and consists of 32 ones, then 01, then 10 for a read or 01 for a write, then the 5-bit PHY address, then the 5-bit register number. A write goes on with 10 and the 16 data bits.
- R4: A write to the command register with bit 31 set starts one frame. Bit 30 selects write (1) or read (0), bits 25:21 hold the register number, bits 20:16 the PHY address and bits 15:0 the data. Bit 31 reads 1 while the frame runs and 0 once it has ended. Control bit 31 reads as the inverse of command bit 31.
- R5: In a read, the master stops driving MDIO from the first turnaround bit to the end of the frame. Command bit 29 reads 1 only when the second turnaround bit was sampled low. Bits 15:0 then hold the 16 bits sampled after turnaround, first sampled bit in bit 15. A line left high gives bit 29 = 0.
- R6: After a write frame, command bit 29 reads 0.
- R7: MDIO output changes only while MDC is low. MDIO input is sampled when MDC rises.
- R8: A command register write while bit 31 reads 1 is ignored: it changes no field and starts no frame.
- R9: A start request while enable (control bit 30) is 0 sends nothing and leaves command bit 31 at 0. If fault-enable (control bit 18) is 1, it sets the fault flag (control bit 19); otherwise the fault flag is unchanged.
- R10: Writing control bit 19 as 1 clears the fault flag. Writing it as 0 leaves the flag as it was.
- R11: Clearing enable in the middle of a frame ends it within two clocks. Command bit 31 reads 0, control bit 31 reads 1, MDIO is released and MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 command |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register |
| mdc | output | 1 | Management clock to the PHYs |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_in | input | 1 | MDIO value seen at the pad |

## Verification
The bench builds the block with its default parameters: a 16-bit divider that resets to 255 and a 32-bit preamble. It checks the reset divider and then reprograms the divider to 0, 1, 3 and 5. The small values make MDC periods of two to six clocks, so many complete 64-bit frames fit in a short run, and they expose both even and odd high/low splits and the divider-zero clamp. The PHY model answers every address except 31, which it leaves floating high, so both the acknowledged and the unacknowledged read paths are exercised, along with the extreme address and register values 0 and 31.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  // command word bit positions (software-visible)
  localparam int CMD_GO     = 31;
  localparam int CMD_WR     = 30;
  localparam int CMD_ACK    = 29;
  localparam int CMD_REG_LO = 21;
  localparam int CMD_PHY_LO = 16;
  // control word bit positions
  localparam int CTL_IDLE   = 31;
  localparam int CTL_EN     = 30;
  localparam int CTL_FAULT  = 19;
  localparam int CTL_FEN    = 18;

  typedef enum logic {SEL_CTRL = 1'b0, SEL_CMD = 1'b1} reg_sel_e;

  typedef struct packed {
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regn;
    logic [15:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
`timescale 1ns/1ps
module mdio_clk_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] div_eff, half_m1, cnt_q;
  logic [DIV_W:0]   sum;

  always_comb begin
    div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
    sum     = {1'b0, div_eff} + {{DIV_W{1'b0}}, 1'b1};
    half_m1 = DIV_W'(sum >> 1) - DIV_W'(1);
  end

  assign rise_o = en_i && (cnt_q >= div_eff);
  assign fall_o = en_i && (cnt_q == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      mdc_o <= 1'b0;
    end else if (rise_o) begin
      cnt_q <= '0;
      mdc_o <= 1'b1;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
      if (fall_o) mdc_o <= 1'b0;
    end
  end

  assert_mdc_low_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !mdc_o);
  assert_ticks_apart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_BITS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable_i,
  input  logic        rise_i,
  input  logic        fall_i,
  input  logic        start_i,
  input  mdio_cmd_t   cmd_i,
  input  logic        mdio_in_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rx_data_o,
  output logic        rx_ack_o,
  output logic        mdio_out_o,
  output logic        mdio_oe_o
);
  localparam int FRAME_LEN = PRE_BITS + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam int REL_IDX   = PRE_BITS + 14;
  localparam int ACK_IDX   = PRE_BITS + 15;
  localparam int DATA_IDX  = PRE_BITS + 16;
  localparam int LAST_IDX  = FRAME_LEN - 1;

  logic [FRAME_LEN-1:0] frame_w, sh_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 busy_q, armed_q, done_q, rd_q, ack_q, mdo_q, oe_q;
  logic [15:0]          rx_q;

  always_comb begin
    frame_w = {{PRE_BITS{1'b1}}, 2'b01,
               cmd_i.wr ? 2'b01 : 2'b10,
               cmd_i.phy, cmd_i.regn,
               cmd_i.wr ? 2'b10 : 2'b11,
               cmd_i.wr ? cmd_i.data : 16'hFFFF};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; idx_q <= '0; busy_q <= 1'b0; armed_q <= 1'b0;
      done_q <= 1'b0; rd_q <= 1'b0; ack_q <= 1'b0; rx_q <= '0;
      mdo_q <= 1'b1; oe_q <= 1'b0;
    end else if (!enable_i) begin
      busy_q <= 1'b0; armed_q <= 1'b0; done_q <= 1'b0; oe_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q  <= 1'b1;
          idx_q   <= '0;
          armed_q <= 1'b0;
          sh_q    <= frame_w;
          rd_q    <= !cmd_i.wr;
          ack_q   <= 1'b0;
        end
      end else if (fall_i && !armed_q) begin
        // drive the next bit while MDC is low
        mdo_q   <= sh_q[FRAME_LEN-1];
        sh_q    <= {sh_q[FRAME_LEN-2:0], 1'b0};
        oe_q    <= !(rd_q && (idx_q >= IDX_W'(REL_IDX)));
        armed_q <= 1'b1;
      end else if (rise_i && armed_q) begin
        // sample on the rising MDC edge
        armed_q <= 1'b0;
        if (rd_q && idx_q == IDX_W'(ACK_IDX)) ack_q <= !mdio_in_i;
        if (rd_q && idx_q >= IDX_W'(DATA_IDX)) rx_q <= {rx_q[14:0], mdio_in_i};
        if (idx_q == IDX_W'(LAST_IDX)) begin
          busy_q <= 1'b0;
          oe_q   <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q + IDX_W'(1);
        end
      end
    end
  end

  assign busy_o     = busy_q || done_q;
  assign done_o     = done_q;
  assign rx_data_o  = rx_q;
  assign rx_ack_o   = ack_q;
  assign mdio_out_o = mdo_q;
  assign mdio_oe_o  = oe_q;

  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable_i |=> (!busy_o && !mdio_oe_o));
  assert_release_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd_q && armed_q && idx_q >= IDX_W'(REL_IDX)) |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_csr.sv
`timescale 1ns/1ps
module mdio_csr
  import mdio_pkg::*;
#(
  parameter int          DIV_W     = 16,
  parameter int unsigned DIV_RESET = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic [15:0]      rx_data_i,
  input  logic             rx_ack_i,
  output logic             enable_o,
  output logic [DIV_W-1:0] div_o,
  output logic             start_o,
  output mdio_cmd_t        cmd_o
);
  logic             en_q, fen_q, fault_q, ack_q;
  logic [DIV_W-1:0] div_q;
  mdio_cmd_t        cmd_q;
  logic             wr_ctl, wr_cmd, accept;
  logic             unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign wr_ctl  = we_i && (sel_i == SEL_CTRL);
  assign wr_cmd  = we_i && (sel_i == SEL_CMD);
  assign accept  = wr_cmd && !busy_i;
  assign start_o = accept && wdata_i[CMD_GO] && en_q;

  always_comb begin
    cmd_o.wr   = wdata_i[CMD_WR];
    cmd_o.regn = wdata_i[CMD_REG_LO +: 5];
    cmd_o.phy  = wdata_i[CMD_PHY_LO +: 5];
    cmd_o.data = wdata_i[15:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; fen_q <= 1'b0; fault_q <= 1'b0; ack_q <= 1'b0;
      div_q <= DIV_W'(DIV_RESET);
      cmd_q <= '0;
    end else begin
      if (wr_ctl) begin
        en_q  <= wdata_i[CTL_EN];
        fen_q <= wdata_i[CTL_FEN];
        div_q <= wdata_i[DIV_W-1:0];
        if (wdata_i[CTL_FAULT]) fault_q <= 1'b0;
      end
      if (accept) begin
        cmd_q <= cmd_o;
        ack_q <= 1'b0;
        if (wdata_i[CMD_GO] && !en_q && fen_q) fault_q <= 1'b1;
      end else if (done_i && !cmd_q.wr) begin
        cmd_q.data <= rx_data_i;
        ack_q      <= rx_ack_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_CTRL) begin
      rdata_o[CTL_IDLE]    = !busy_i;
      rdata_o[CTL_EN]      = en_q;
      rdata_o[CTL_FAULT]   = fault_q;
      rdata_o[CTL_FEN]     = fen_q;
      rdata_o[DIV_W-1:0]   = div_q;
    end else begin
      rdata_o[CMD_GO]           = busy_i;
      rdata_o[CMD_WR]           = cmd_q.wr;
      rdata_o[CMD_ACK]          = ack_q;
      rdata_o[CMD_REG_LO +: 5]  = cmd_q.regn;
      rdata_o[CMD_PHY_LO +: 5]  = cmd_q.phy;
      rdata_o[15:0]             = cmd_q.data;
    end
  end

  assign enable_o = en_q;
  assign div_o    = div_q;

  assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && busy_i) |=> ($stable(cmd_q.phy) && $stable(cmd_q.regn) && $stable(cmd_q.wr)));
  assert_no_start_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && wdata_i[CMD_GO] && !en_q && !busy_i) |=> !busy_i);
  assert_fault_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !busy_i && wdata_i[CMD_GO] && !en_q && fen_q) |=> fault_q);
  assert_fault_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctl && wdata_i[CTL_FAULT]) |=> !fault_q);
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int          DIV_W     = 16,
  parameter int unsigned DIV_RESET = 255,
  parameter int          PRE_BITS  = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic        reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_out,
  output logic        mdio_oe,
  input  logic        mdio_in
);
  logic             enable, start, busy, done, rx_ack, rise, fall;
  logic [DIV_W-1:0] div;
  logic [15:0]      rx_data;
  mdio_cmd_t        cmd;

  mdio_csr #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_csr (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .sel_i(reg_addr),
    .wdata_i(reg_wdata), .rdata_o(reg_rdata), .busy_i(busy), .done_i(done),
    .rx_data_i(rx_data), .rx_ack_i(rx_ack), .enable_o(enable), .div_o(div),
    .start_o(start), .cmd_o(cmd)
  );

  mdio_clk_div #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .div_i(div),
    .mdc_o(mdc), .rise_o(rise), .fall_o(fall)
  );

  mdio_frame_engine #(.PRE_BITS(PRE_BITS)) u_eng (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .rise_i(rise), .fall_i(fall),
    .start_i(start), .cmd_i(cmd), .mdio_in_i(mdio_in), .busy_o(busy),
    .done_o(done), .rx_data_o(rx_data), .rx_ack_o(rx_ack),
    .mdio_out_o(mdio_out), .mdio_oe_o(mdio_oe)
  );

  assert_out_mdc_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_out) |-> !mdc);
endmodule

// File: tb/test_mdio_mgmt_master.sv
`timescale 1ns/1ps
module test_mdio_mgmt_master;
  logic        clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  wire  [31:0] reg_rdata;
  wire         mdc, mdio_out, mdio_oe;
  logic        phy_drv = 1'b1;
  wire         mdio_in = mdio_oe ? mdio_out : phy_drv;
  int          checks = 0, errors = 0, frames = 0, r7_bad = 0;
  bit          finished = 1'b0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  mdio_mgmt_master i_mdio_mgmt_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(mdio_in)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(logic a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(logic a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  function automatic logic [15:0] phy_resp(logic [4:0] p, logic [4:0] r);
    return {p, r, 6'h15} ^ 16'hA5C3;
  endfunction

  task automatic wait_idle(output logic [31:0] d);
    d = 32'h8000_0000;
    for (int n = 0; n < 2000 && d[31]; n++) rd_reg(1'b1, d);
  endtask

  // driver: push expected frame, issue command, check completion results
  task automatic xfer(bit wr, logic [4:0] p, logic [4:0] r, logic [15:0] d);
    logic [31:0] v;
    exp_q.push_back({5'b0, wr, p, r, wr ? d : 16'h0});
    wr_reg(1'b1, {1'b1, wr, 1'b0, 3'b0, r, p, d});
    rd_reg(1'b1, v); check("R4 GO reads 1 while frame runs", v[31], 1);
    rd_reg(1'b0, v); check("R4 control idle reads 0 while busy", v[31], 0);
    wait_idle(v);    check("R4 GO clears by itself", v[31], 0);
    if (wr) check("R6 ack after write", v[29], 0);
    else if (p == 5'd31) check("R5 ack with no PHY", v[29], 0);
    else begin
      check("R5 ack from PHY", v[29], 1);
      check("R5 read data", v[15:0], phy_resp(p, r));
    end
  endtask

  task automatic measure(int per, int hi, string tag);
    time t0, t1, t2;
    @(posedge mdc); @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    check({"R2 MDC period ", tag}, 32'((t2 - t0) / 20), per);
    check({"R2 MDC high time ", tag}, 32'((t1 - t0) / 20), hi);
  endtask

  // PHY model and monitor
  initial begin
    logic [63:0] fb;
    logic [31:0] e;
    logic [15:0] resp;
    logic [4:0]  cp;
    bit rd, rel_ok;
    forever begin
      @(posedge mdio_oe);
      rd = 1'b0; rel_ok = 1'b1; fb = '0; resp = '0; cp = '0;
      for (int k = 0; k < 64; k++) begin
        @(posedge mdc);
        fb[63-k] = mdio_out;
        if (k == 35) rd = (fb[29:28] == 2'b10);
        if (k == 45) begin cp = fb[27:23]; resp = phy_resp(fb[27:23], fb[22:18]); end
        if (rd && k >= 46 && mdio_oe) rel_ok = 1'b0;
        if (rd && k >= 46 && k < 63) begin
          @(negedge mdc);
          if (cp == 5'd31) phy_drv = 1'b1;
          else if (k + 1 == 47) phy_drv = 1'b0;
          else phy_drv = resp[63-(k+1)];
        end
      end
      phy_drv = 1'b1;
      frames++;
      if (exp_q.size() == 0) check("R3 unexpected frame", fb[31:0], 32'hDEAD_0000);
      else begin
        e = exp_q.pop_front();
        check("R3 preamble", fb[63:32], 32'hFFFF_FFFF);
        check("R3 start bits", fb[31:30], 2'b01);
        check("R3 opcode", fb[29:28], e[26] ? 2'b01 : 2'b10);
        check("R3 phy address", fb[27:23], e[25:21]);
        check("R3 register number", fb[22:18], e[20:16]);
        if (e[26]) begin
          check("R3 write turnaround", fb[17:16], 2'b10);
          check("R3 write data", fb[15:0], e[15:0]);
        end else check("R5 line released in read", rel_ok, 1);
      end
    end
  end

  // R7: output may only change while MDC is low
  initial begin
    wait (rst_n);
    forever begin
      @(mdio_out); #1;
      if (mdc) r7_bad++;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd_reg(1'b0, v); check("R1 control reset", v, 32'h8000_00FF);
    rd_reg(1'b1, v); check("R1 command reset", v, 32'h0);
    check("R1 mdc low", mdc, 0);
    check("R1 mdio released", mdio_oe, 0);
    repeat (20) @(negedge clk);
    check("R2 mdc low while disabled", mdc, 0);

    wr_reg(1'b0, 32'h4000_0003); measure(4, 2, "div3");
    wr_reg(1'b0, 32'h4000_0005); measure(6, 3, "div5");
    wr_reg(1'b0, 32'h4000_0000); measure(2, 1, "div0");
    wr_reg(1'b0, 32'h4000_0003);
    rd_reg(1'b0, v); check("R2 control readback", v, 32'hC000_0003);

    xfer(1'b1, 5'd1,  5'd0,  16'h1234);
    xfer(1'b0, 5'd1,  5'd2,  16'h0);
    xfer(1'b0, 5'd31, 5'd1,  16'h0);
    xfer(1'b1, 5'd30, 5'd31, 16'hFFFF);
    xfer(1'b0, 5'd0,  5'd31, 16'h0);
    wr_reg(1'b0, 32'h4000_0001);
    xfer(1'b0, 5'd17, 5'd9,  16'h0);
    wr_reg(1'b0, 32'h4000_0003);

    // R8: second command while busy is ignored
    n0 = frames;
    exp_q.push_back({5'b0, 1'b1, 5'd3, 5'd4, 16'hBEEF});
    wr_reg(1'b1, {1'b1, 1'b1, 1'b0, 3'b0, 5'd4, 5'd3, 16'hBEEF});
    wr_reg(1'b1, {1'b1, 1'b0, 1'b0, 3'b0, 5'd7, 5'd9, 16'h0});
    wait_idle(v);
    check("R8 phy field kept", v[20:16], 5'd3);
    check("R8 register field kept", v[25:21], 5'd4);
    check("R8 direction kept", v[30], 1);
    check("R8 data kept", v[15:0], 16'hBEEF);
    repeat (300) @(negedge clk);
    check("R8 only one frame sent", frames, n0 + 1);

    // R9/R10: request while disabled
    wr_reg(1'b0, 32'h0004_0003);
    n0 = frames;
    wr_reg(1'b1, {1'b1, 1'b0, 1'b0, 3'b0, 5'd1, 5'd2, 16'h0});
    rd_reg(1'b1, v); check("R9 GO stays 0 when disabled", v[31], 0);
    rd_reg(1'b0, v); check("R9 fault set", v, 32'h800C_0003);
    repeat (50) @(negedge clk);
    check("R9 no frame when disabled", frames, n0);
    check("R9 line not driven", mdio_oe, 0);
    wr_reg(1'b0, 32'h0004_0003);
    rd_reg(1'b0, v); check("R10 fault kept on write of 0", v[19], 1);
    wr_reg(1'b0, 32'h000C_0003);
    rd_reg(1'b0, v); check("R10 fault cleared by write of 1", v, 32'h8004_0003);
    wr_reg(1'b0, 32'h0000_0003);
    wr_reg(1'b1, {1'b1, 1'b0, 1'b0, 3'b0, 5'd1, 5'd2, 16'h0});
    rd_reg(1'b0, v); check("R9 no fault when fault-enable is 0", v[19], 0);

    check("R7 output changed only with MDC low", r7_bad, 0);
    check("R3 all expected frames seen", exp_q.size(), 0);

    // R11: abort by clearing enable mid-frame
    wr_reg(1'b0, 32'h4000_0003);
    wr_reg(1'b1, {1'b1, 1'b0, 1'b0, 3'b0, 5'd2, 5'd5, 16'h0});
    repeat (60) @(negedge clk);
    wr_reg(1'b0, 32'h0000_0003);
    repeat (2) @(negedge clk);
    rd_reg(1'b1, v); check("R11 GO cleared on abort", v[31], 0);
    rd_reg(1'b0, v); check("R11 idle after abort", v, 32'h8000_0003);
    check("R11 line released", mdio_oe, 0);
    check("R11 mdc low", mdc, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule